// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block gives a processor access to a set of general-purpose pins, arranged as several banks of up to 32 pins. Software reaches it through a plain 32-bit register bus with separate read and write strobes. Each bank has registers for the sampled pin level, the output enable, per-pin rising and falling capture enables, a sticky edge-status word and an interrupt mask. Output levels are never written directly. Software changes them only through a write-one-to-set word and a write-one-to-clear word, so two agents can drive different pins without a read-modify-write.

Every pin input passes through a two-flop synchronizer. Level reads and edge detection both use the synchronized value. An edge is a difference between the synchronized value and its value one cycle earlier. A captured edge stays pending until software writes a one to its status bit. Each bank's pending bits are gated by its mask, and the results from all banks are ORed into a single registered interrupt level.

The address map keeps each register kind in a group of consecutive words, with the banks interleaved at a 4-byte stride. Banks 0 to 2 sit in the lower group. Banks 3 to 5 sit in a second group starting at 0x100. The last bank may carry fewer than 32 pins.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pin_out`, `pin_oe`, `irq` and `bus_rdata` are zero, and every register reads zero, except the edge mask, which reads all ones over the bank's implemented pins.
- R2: A register address is the bank offset plus the kind offset. The bank offset is `b*4` for banks b < 3 and `0x100 + (b-3)*4` for banks b ≥ 3. The kind offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48 and edge mask 0x9C. A read returns the data in `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` is zero in cycles that follow no read.
- R3: A write to the set word drives high each `pin_out` bit written as 1, and a write to the clear word drives low each bit written as 1. Bits written as 0 keep their level. Both words read as zero, and `pin_out` changes only through these two words.
- R4: The direction word is readable and writable. A bit of 1 drives the matching `pin_oe` bit high (output), and a bit of 0 makes the pin an input.
- R5: The level word returns the synchronized `pin_in` value of the bank, for input and output pins alike.
- R6: A 0-to-1 transition of a synchronized pin sets its status bit only when its rising-enable bit is 1.
- R7: A 1-to-0 transition sets its status bit only when its falling-enable bit is 1. With both enables set, both kinds of edge are captured.
- R8: Writing 1 to a status bit clears it. Status bits written as 0 keep their value.
- R9: If an enabled edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: `irq` is a registered level equal to the OR, over all banks, of (status AND mask), taken one cycle earlier. A masked status bit stays pending but does not raise `irq`.
- R11: In the last bank, bits above LAST_BANK_PINS read as zero in every register, ignore writes, and never set status.
- R12: Writes to undecoded addresses change no state, and reads of them return zero. Undecoded addresses are: unaligned addresses, offsets outside the eight kinds, and banks at or above NUM_BANKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32*(NUM_BANKS-1)+LAST_BANK_PINS | Pin input levels, bank b at bit b*32 |
| pin_out | output | 32*(NUM_BANKS-1)+LAST_BANK_PINS | Output levels |
| pin_oe | output | 32*(NUM_BANKS-1)+LAST_BANK_PINS | Output enables (1 = drive) |
| irq | output | 1 | Combined edge interrupt level |

## Verification
The address walk writes a distinct pattern into each bank's direction word in both address groups and reads every pattern back. This separates bank interleave and group relocation faults from kind-offset faults, which a single bank would hide. Edge capture is driven with rising-only, falling-only and both-edge enables, plus transitions on pins whose enables are off, so that a swapped or ORed enable shows up. Clear behaviour is tested with zero bits and with a clear that lands in the same cycle as a new edge. Masking is tested with events pending in two banks at once, which shows whether `irq` really combines banks and honours each mask.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and the register-kind type for the banked GPIO controller.
// Assumes at most six banks, split over two address groups of three banks.
package gpio_bank_pkg;
    localparam int WORD_W      = 32;
    localparam int BANK_PINS   = 32;
    localparam int ADDR_W      = 9;
    localparam int BANK_IDX_W  = 3;
    localparam int MAX_BANKS   = 6;
    localparam int GROUP_BANKS = 3;

    typedef enum logic [3:0] {
        RK_LEVEL,
        RK_DIR,
        RK_SET,
        RK_CLR,
        RK_RISE,
        RK_FALL,
        RK_STAT,
        RK_MASK,
        RK_NONE
    } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Address decoder: turns a byte address into (hit, bank index, register kind).
// Each kind owns three consecutive words per group, and the upper group
// starts at 0x100. Assumes ADDR_W of 9 and NUM_BANKS no larger than MAX_BANKS.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [BANK_IDX_W-1:0] bank_idx,
    output reg_kind_e             kind
);
    localparam int KIND_WORDS = 7 * GROUP_BANKS;     // words 0..20
    localparam int MASK_WORD  = 39;                  // 0x9C >> 2

    logic [5:0]            word;
    logic [1:0]            sub;
    logic [3:0]            type_idx;
    logic [BANK_IDX_W-1:0] bank_full;
    reg_kind_e             kind_raw;

    // Split the in-group word index into kind and bank-within-group.
    always_comb begin
        word     = addr[7:2];
        sub      = 2'd0;
        type_idx = 4'd0;
        kind_raw = RK_NONE;
        if (word < 6'(KIND_WORDS)) begin
            type_idx = 4'(word / 6'd3);
            sub      = 2'(word % 6'd3);
            case (type_idx)
                4'd0:    kind_raw = RK_LEVEL;
                4'd1:    kind_raw = RK_DIR;
                4'd2:    kind_raw = RK_SET;
                4'd3:    kind_raw = RK_CLR;
                4'd4:    kind_raw = RK_RISE;
                4'd5:    kind_raw = RK_FALL;
                4'd6:    kind_raw = RK_STAT;
                default: kind_raw = RK_NONE;
            endcase
        end else if (word >= 6'(MASK_WORD) && word < 6'(MASK_WORD + GROUP_BANKS)) begin
            sub      = 2'(word - 6'(MASK_WORD));
            kind_raw = RK_MASK;
        end
        bank_full = addr[8] ? (3'(GROUP_BANKS) + {1'b0, sub}) : {1'b0, sub};
    end

    assign hit      = (addr[1:0] == 2'b00) && (kind_raw != RK_NONE)
                      && (bank_full < 3'(NUM_BANKS));
    assign bank_idx = bank_full;
    assign kind     = hit ? kind_raw : RK_NONE;
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent, so no multi-bit coherence is needed.
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // Shift the raw inputs through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// One bank of pins: output level, direction, edge enables, sticky status
// and interrupt mask, plus the read mux for its registers.
// Assumes pin_lvl is already synchronized and that wr_sel is high only
// when this bank is addressed by a decoded write.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  reg_kind_e         kind,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  pin_lvl,
    output logic [WORD_W-1:0] rd_word,
    output logic [NPINS-1:0]  out_lvl,
    output logic [NPINS-1:0]  out_en,
    output logic              pend
);
    logic [NPINS-1:0] out_q, dir_q, rise_q, fall_q, stat_q, mask_q, prev_q;
    logic [NPINS-1:0] edge_hit, clr_bits;

    // Rising and falling events, each gated by its own enable.
    assign edge_hit = (pin_lvl & ~prev_q & rise_q) | (~pin_lvl & prev_q & fall_q);
    assign clr_bits = (wr_sel && kind == RK_STAT) ? wdata : '0;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_lvl;
    end

    // Output level changes only through the set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)                           out_q <= '0;
        else if (wr_sel && kind == RK_SET)    out_q <= out_q | wdata;
        else if (wr_sel && kind == RK_CLR)    out_q <= out_q & ~wdata;
    end

    // Plain read/write configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= '1;
        end else if (wr_sel) begin
            case (kind)
                RK_DIR:  dir_q  <= wdata;
                RK_RISE: rise_q <= wdata;
                RK_FALL: fall_q <= wdata;
                RK_MASK: mask_q <= wdata;
                default: ;
            endcase
        end
    end

    // Sticky status: write-one-to-clear, with a new event taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | edge_hit;
    end

    // Read mux, zero-extended to the bus width.
    always_comb begin
        case (kind)
            RK_LEVEL: rd_word = WORD_W'(pin_lvl);
            RK_DIR:   rd_word = WORD_W'(dir_q);
            RK_RISE:  rd_word = WORD_W'(rise_q);
            RK_FALL:  rd_word = WORD_W'(fall_q);
            RK_STAT:  rd_word = WORD_W'(stat_q);
            RK_MASK:  rd_word = WORD_W'(mask_q);
            default:  rd_word = '0;
        endcase
    end

    assign out_lvl = out_q;
    assign out_en  = dir_q;
    assign pend    = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_banked_ctrl.sv
// Top level of the banked GPIO controller: bus decode, pin synchronizer,
// one gpio_bank per bank, the registered read port and the combined interrupt.
// Assumes 1 <= NUM_BANKS <= 6 and 1 <= LAST_BANK_PINS <= 32.
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int  NUM_BANKS      = 4,
    parameter int  LAST_BANK_PINS = 20,
    localparam int TOTAL_PINS     = BANK_PINS * (NUM_BANKS - 1) + LAST_BANK_PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [TOTAL_PINS-1:0] pin_in,
    output logic [TOTAL_PINS-1:0] pin_out,
    output logic [TOTAL_PINS-1:0] pin_oe,
    output logic                  irq
);
    logic                  dec_hit;
    logic [BANK_IDX_W-1:0] dec_bank;
    reg_kind_e             dec_kind;
    logic [TOTAL_PINS-1:0] pin_sync;
    logic [WORD_W-1:0]     bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0]  pend_vec;
    logic [WORD_W-1:0]     sel_rd;
    logic                  pend_any;

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr     (bus_addr),
        .hit      (dec_hit),
        .bank_idx (dec_bank),
        .kind     (dec_kind)
    );

    gpio_sync #(.WIDTH(TOTAL_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int NP = (b == NUM_BANKS - 1) ? LAST_BANK_PINS : BANK_PINS;
        logic wr_sel;
        assign wr_sel = bus_wr && dec_hit && (dec_bank == BANK_IDX_W'(b));

        gpio_bank #(.NPINS(NP)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_sel),
            .kind    (dec_kind),
            .wdata   (bus_wdata[NP-1:0]),
            .pin_lvl (pin_sync[b*BANK_PINS +: NP]),
            .rd_word (bank_rd[b]),
            .out_lvl (pin_out[b*BANK_PINS +: NP]),
            .out_en  (pin_oe[b*BANK_PINS +: NP]),
            .pend    (pend_vec[b])
        );
    end

    // Pick the read word of the addressed bank.
    always_comb begin
        sel_rd = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_bank == BANK_IDX_W'(b)) sel_rd = bank_rd[b];
        end
    end

    assign pend_any = |pend_vec;

    // Register the read data; zero when no decoded read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_rd && dec_hit) bus_rdata <= sel_rd;
        else                        bus_rdata <= '0;
    end

    // Register the combined interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= pend_any;
    end
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
// Assertion checker for gpio_banked_ctrl, attached with bind.
// Assumes it sees the top's ports plus its decode hit and pending summary.
module gpio_banked_ctrl_chk #(
    parameter int W = 116
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          dec_hit,
    input logic [31:0]   bus_rdata,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe,
    input logic          irq,
    input logic          pend_any
);
    logic rst_prev_q;

    // Track reset so the first cycle after release can be checked.
    always_ff @(posedge clk) begin
        rst_prev_q <= rst_n;
        if (rst_n && rst_prev_q === 1'b0) begin
            assert_reset_state_R1: assert (pin_out == '0 && pin_oe == '0 && !irq && bus_rdata == '0)
                else $error("reset state wrong");
        end
    end

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out));

    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_oe));

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(pend_any));

    assert_undecoded_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dec_hit) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.W(TOTAL_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .dec_hit   (dec_hit),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .pend_any  (pend_any)
);

// File: tb/sim_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_banked_ctrl;
    localparam int TP = 116;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_wr, bus_rd;
    logic [8:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [TP-1:0]   pin_in, pin_out, pin_oe;
    logic            irq;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    gpio_banked_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Vector: {is_write, addr[8:0], data[31:0], expect[31:0]} (R2 address walk, R11 partial bank)
    localparam logic [73:0] VEC [0:13] = '{
        {1'b1, 9'h00C, 32'h0000_00FF, 32'h0},
        {1'b1, 9'h010, 32'h0000_FF00, 32'h0},
        {1'b1, 9'h014, 32'h00FF_0000, 32'h0},
        {1'b1, 9'h10C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 9'h00C, 32'h0,         32'h0000_00FF},
        {1'b0, 9'h010, 32'h0,         32'h0000_FF00},
        {1'b0, 9'h014, 32'h0,         32'h00FF_0000},
        {1'b0, 9'h10C, 32'h0,         32'h000F_FFFF},
        {1'b1, 9'h018, 32'h0000_00A5, 32'h0},
        {1'b0, 9'h018, 32'h0,         32'h0},
        {1'b1, 9'h034, 32'h0000_0001, 32'h0},
        {1'b0, 9'h034, 32'h0,         32'h0000_0001},
        {1'b0, 9'h040, 32'h0,         32'h0},
        {1'b0, 9'h19C, 32'h0,         32'h000F_FFFF}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [TP-1:0] oe_exp, out_snap, oe_snap;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", irq, 0);
        read_check("R1 mask bank1", 9'h0A0, 32'hFFFF_FFFF);
        read_check("R1 status bank0", 9'h048, 32'h0);
        read_check("R1 dir bank3", 9'h10C, 32'h0);

        // R2 / R11 table walk
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][73]) bus_write(VEC[i][72:64], VEC[i][63:32]);
            else            read_check("R2 table read", VEC[i][72:64], VEC[i][31:0]);
        end

        // R3 set / clear
        check("R3 set A5", pin_out, TP'(32'hA5));
        bus_write(9'h024, 32'h05);
        check("R3 clear 05", pin_out, TP'(32'hA0));
        bus_write(9'h018, 32'h0);
        check("R3 zero set keeps", pin_out, TP'(32'hA0));
        bus_write(9'h018, 32'h0F);
        check("R3 set 0F", pin_out, TP'(32'hAF));
        read_check("R3 clear reads zero", 9'h024, 32'h0);

        // R4 direction
        oe_exp = '0;
        oe_exp[7:0] = 8'hFF; oe_exp[47:40] = 8'hFF; oe_exp[87:80] = 8'hFF; oe_exp[115:96] = '1;
        check("R4 pin_oe map", pin_oe, oe_exp);
        bus_write(9'h00C, 32'h0F);
        oe_exp[7:0] = 8'h0F;
        check("R4 pin_oe rewrite", pin_oe, oe_exp);
        read_check("R4 dir readback", 9'h00C, 32'h0F);

        // R5 level
        @(negedge clk); pin_in[67] = 1'b1; pin_in[115] = 1'b1;
        wait_cyc(4);
        read_check("R5 level bank2", 9'h008, 32'h8);
        read_check("R5 level bank0", 9'h000, 32'h0);
        read_check("R5 level bank3", 9'h100, 32'h0008_0000);

        // R6 rising capture
        bus_write(9'h038, 32'h3);
        @(negedge clk); pin_in[64] = 1'b1; pin_in[66] = 1'b1;
        wait_cyc(4);
        read_check("R6 rise enabled only", 9'h050, 32'h1);
        check("R10 irq raised", irq, 1);
        @(negedge clk); pin_in[67] = 1'b0;
        wait_cyc(4);
        read_check("R6 fall not enabled", 9'h050, 32'h1);

        // R8 write-one-to-clear
        bus_write(9'h050, 32'h0);
        read_check("R8 zero write keeps", 9'h050, 32'h1);
        bus_write(9'h050, 32'h2);
        read_check("R8 other bit keeps", 9'h050, 32'h1);
        bus_write(9'h050, 32'h1);
        read_check("R8 cleared", 9'h050, 32'h0);
        wait_cyc(1);
        check("R10 irq dropped", irq, 0);

        // R7 falling and both edges
        bus_write(9'h044, 32'h30);
        bus_write(9'h038, 32'h23);
        @(negedge clk); pin_in[68] = 1'b1;
        wait_cyc(4);
        read_check("R7 rise on fall-only pin", 9'h050, 32'h0);
        @(negedge clk); pin_in[68] = 1'b0;
        wait_cyc(4);
        read_check("R7 fall captured", 9'h050, 32'h10);
        @(negedge clk); pin_in[69] = 1'b1;
        wait_cyc(4);
        read_check("R7 both: rise", 9'h050, 32'h30);
        bus_write(9'h050, 32'h20);
        read_check("R8 partial clear", 9'h050, 32'h10);
        @(negedge clk); pin_in[69] = 1'b0;
        wait_cyc(4);
        read_check("R7 both: fall", 9'h050, 32'h30);
        bus_write(9'h050, 32'hFFFF_FFFF);
        read_check("R8 clear all", 9'h050, 32'h0);

        // R10 mask and cross-bank OR
        @(negedge clk); pin_in[68] = 1'b1;
        @(negedge clk); pin_in[68] = 1'b0;
        bus_write(9'h0A4, 32'h0);
        wait_cyc(4);
        check("R10 masked no irq", irq, 0);
        read_check("R10 masked still pending", 9'h050, 32'h10);
        read_check("R10 mask readback", 9'h0A4, 32'h0);
        bus_write(9'h130, 32'h1);
        @(negedge clk); pin_in[96] = 1'b1;
        wait_cyc(4);
        check("R10 bank3 raises irq", irq, 1);
        bus_write(9'h148, 32'h1);
        wait_cyc(2);
        check("R10 bank3 cleared", irq, 0);
        bus_write(9'h0A4, 32'hFFFF_FFFF);
        wait_cyc(2);
        check("R10 unmask raises irq", irq, 1);
        bus_write(9'h050, 32'hFFFF_FFFF);
        wait_cyc(2);
        check("R10 cleared irq", irq, 0);

        // R9 edge and clear in the same cycle
        bus_write(9'h038, 32'h63);
        @(negedge clk); pin_in[70] = 1'b1;
        @(negedge clk);
        bus_write(9'h050, 32'h40);
        read_check("R9 event wins", 9'h050, 32'h40);
        bus_write(9'h050, 32'h40);
        read_check("R9 later clear", 9'h050, 32'h0);

        // R11 partial last bank
        bus_write(9'h130, 32'hFFFF_FFFF);
        read_check("R11 rise bank3 width", 9'h130, 32'h000F_FFFF);
        bus_write(9'h118, 32'hFFFF_FFFF);
        check("R11 set bank3", pin_out[115:96], 20'hFFFFF);
        read_check("R11 no stray status", 9'h148, 32'h0);

        // R12 undecoded addresses
        bus_write(9'h054, 32'hFFFF_FFFF);
        read_check("R12 gap reads zero", 9'h054, 32'h0);
        out_snap = pin_out; oe_snap = pin_oe;
        bus_write(9'h110, 32'hFFFF_FFFF);
        bus_write(9'h00D, 32'hFFFF_FFFF);
        bus_write(9'h11C, 32'hFFFF_FFFF);
        bus_write(9'h030, 32'h0000_0000);
        check("R12 oe unchanged", pin_oe, oe_snap);
        check("R12 out unchanged", pin_out, out_snap);
        read_check("R12 absent bank reads zero", 9'h110, 32'h0);
        read_check("R12 dir bank0 kept", 9'h00C, 32'h0F);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule